// File: doc/BRIEF.md
# Wide-to-Narrow Bus Width Downsizer

This block takes a stream of 36-bit words on a valid/ready input and delivers it on a valid/ready output whose useful width is 36, 18 or 9 bits. It is placed between a wide producer and a narrow consumer. For each wide word it emits one, two or four pieces. The consumer reads the low bits of `out_data` that belong to the selected width, and all bits above them are zero.

Two selects set the width, and both stay fixed after reset. `narrow_en` low gives long-word mode, where each word passes through whole and `size_sel` has no effect. `narrow_en` high gives word mode when `size_sel` is low and byte mode when `size_sel` is high. A 9-bit byte lane holds eight data bits and one parity bit, and the block passes all nine bits without change. The `order_pin` input is sampled while reset is asserted and sets the piece order: high gives most-significant-first and low gives least-significant-first. After reset the same pin may carry an unrelated signal. The latched order is not affected by it.

The controller has two states. In `ST_IDLE` the block holds no word and raises `in_ready`. The transition **accept** (`in_valid` high) captures the word, clears the piece index and moves to `ST_SEND`. In `ST_SEND` the block presents the current piece with `out_valid` high. The transition **step** (`out_ready` high while the index is below the last piece) advances the index and stays in `ST_SEND`. The transition **drain** (`out_ready` high on the last piece) returns to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `bus_downsizer`

## Requirements
- R1: With `narrow_en` low, each accepted word is delivered as exactly one output piece equal to the full 36-bit word, and `size_sel` has no effect.
- R2: In word mode (`narrow_en`=1, `size_sel`=0), each word is delivered as two pieces. One piece is bits 35:18 and the other is bits 17:0, each placed in `out_data[17:0]` with `out_data[35:18]` zero.
- R3: In byte mode (`narrow_en`=1, `size_sel`=1), each word is delivered as four 9-bit pieces. Lane k is bits 9k+8:9k, and each piece is placed in `out_data[8:0]` with `out_data[35:9]` zero.
- R4: If `order_pin` was 1 during reset, pieces leave most-significant first: the upper half first in word mode, and lanes 3, 2, 1, 0 in byte mode.
- R5: If `order_pin` was 0 during reset, pieces leave least-significant first: the lower half first in word mode, and lanes 0, 1, 2, 3 in byte mode.
- R6: After reset is released, changes on `order_pin` do not change the piece order until the next reset.
- R7: `in_ready` stays low from the cycle after a word is accepted until the last piece of that word has been taken. A word offered during that time is not captured.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value on the next cycle.
- R9: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R10: `narrow_en` and `size_sel` stay constant while reset is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| narrow_en | input | 1 | 0 selects long-word mode, 1 selects a narrow mode |
| size_sel | input | 1 | In a narrow mode: 0 selects word, 1 selects byte |
| order_pin | input | 1 | Sampled during reset: 1 selects most-significant first |
| in_valid | input | 1 | Wide word offered |
| in_ready | output | 1 | Wide word can be taken |
| in_data | input | 36 | Wide word |
| out_valid | output | 1 | Piece is presented |
| out_ready | input | 1 | Consumer takes the piece |
| out_data | output | 36 | Piece, zero-extended above the selected width |

## Verification
The bench targets the mode and order combinations one at a time, each after its own reset. A design that swapped the order would deliver lanes reversed, and a design that latched the order pin continuously would flip order when the pin is toggled after reset. It offers a second word while pieces are still pending. A design that raised `in_ready` early would lose or overwrite the word being split. It also stalls the output for several cycles and checks for a piece that moves or disappears, and it checks that the piece count ends cleanly with no extra beat after the last piece.

// File: rtl/bus_downsizer_pkg.sv
package bus_downsizer_pkg;
    localparam int WIDE_W = 36;
    localparam int LANE_W = 9;
    localparam int LANES  = WIDE_W / LANE_W;
    localparam int HALF_W = WIDE_W / 2;
    localparam int IDX_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        MODE_LONG = 2'd0,
        MODE_WORD = 2'd1,
        MODE_BYTE = 2'd2
    } width_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } dsz_state_t;
endpackage

// File: rtl/bus_downsizer_cfg.sv
module bus_downsizer_cfg
    import bus_downsizer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_en,
    input  logic              size_sel,
    input  logic              order_pin,
    output width_mode_t       mode,
    output logic              msb_first,
    output logic [IDX_W-1:0]  last_idx
);
    logic order_q;

    // The order is loaded only while reset is held; afterwards the pin is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= order_pin;
        end
    end

    assign msb_first = order_q;

    always_comb begin
        if (!narrow_en) begin
            mode = MODE_LONG;
        end else if (size_sel) begin
            mode = MODE_BYTE;
        end else begin
            mode = MODE_WORD;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_LONG: last_idx = '0;
            MODE_WORD: last_idx = IDX_W'(1);
            MODE_BYTE: last_idx = IDX_W'(LANES - 1);
            default:   last_idx = '0;
        endcase
    end

    // R6: the latched order holds once reset is gone
    assert_order_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(order_q));

    // R10: width selects are static in operation
    assert_selects_static_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(narrow_en) && $stable(size_sel)));
endmodule

// File: rtl/bus_downsizer_lane_mux.sv
module bus_downsizer_lane_mux
    import bus_downsizer_pkg::*;
(
    input  width_mode_t       mode,
    input  logic              msb_first,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WIDE_W-1:0] word,
    output logic [WIDE_W-1:0] piece
);
    logic [LANE_W-1:0] lanes [LANES];
    logic [IDX_W-1:0]  lane_sel;
    logic              half_sel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*LANE_W +: LANE_W];
    end

    assign lane_sel = msb_first ? (IDX_W'(LANES - 1) - idx) : idx;
    assign half_sel = idx[0] ^ msb_first;

    always_comb begin
        piece = '0;
        unique case (mode)
            MODE_LONG: piece = word;
            MODE_WORD: piece[HALF_W-1:0] = half_sel ? word[WIDE_W-1 -: HALF_W]
                                                     : word[HALF_W-1:0];
            MODE_BYTE: piece[LANE_W-1:0] = lanes[lane_sel];
            default:   piece = '0;
        endcase
    end
endmodule

// File: rtl/bus_downsizer.sv
module bus_downsizer
    import bus_downsizer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_en,
    input  logic              size_sel,
    input  logic              order_pin,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WIDE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WIDE_W-1:0] out_data
);
    width_mode_t       mode;
    logic              msb_first;
    logic [IDX_W-1:0]  last_idx;
    dsz_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [WIDE_W-1:0] word_q;
    logic              at_last;

    bus_downsizer_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .narrow_en (narrow_en),
        .size_sel  (size_sel),
        .order_pin (order_pin),
        .mode      (mode),
        .msb_first (msb_first),
        .last_idx  (last_idx)
    );

    bus_downsizer_lane_mux u_mux (
        .mode      (mode),
        .msb_first (msb_first),
        .idx       (idx_q),
        .word      (word_q),
        .piece     (out_data)
    );

    assign at_last = (idx_q == last_idx);

    // Next-state: accept, step, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)             state_d = ST_SEND;
            ST_SEND: if (out_ready && at_last) state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // State register with the held word and piece index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        word_q <= in_data;
                        idx_q  <= '0;
                    end
                end
                ST_SEND: begin
                    if (out_ready) begin
                        idx_q <= at_last ? '0 : idx_q + IDX_W'(1);
                    end
                end
                default: idx_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_SEND: out_valid = 1'b1;
            default: in_ready  = 1'b0;
        endcase
    end

    // R7: an accepted word produces a piece on the next cycle and blocks input
    assert_accept_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !in_ready));

    // R8: stalled piece holds
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R1: long-word mode drains after a single piece
    assert_long_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!narrow_en && out_valid && out_ready) |=> in_ready);

    // R3: byte mode keeps the upper bits clear
    assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_en && size_sel && out_valid) |-> (out_data[WIDE_W-1:LANE_W] == '0));

    // R2: word mode keeps the upper half clear
    assert_word_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_en && !size_sel && out_valid) |-> (out_data[WIDE_W-1:HALF_W] == '0));

    // R9: first cycle after reset is idle
    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (in_ready && !out_valid));
endmodule

// File: tb/bus_downsizer_test.sv
module bus_downsizer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic             narrow;
        logic             size;
        logic             order;
        logic [35:0]      word;
        logic [2:0]       count;
        logic [3:0][35:0] exp;   // exp[0] is delivered first
    } vec_t;

    localparam logic [8:0]  L0 = 9'h042, L1 = 9'h17E, L2 = 9'h0C3, L3 = 9'h1A5;
    localparam logic [35:0] WIN = {L3, L2, L1, L0};
    localparam logic [35:0] E0 = {27'd0, L0}, E1 = {27'd0, L1};
    localparam logic [35:0] E2 = {27'd0, L2}, E3 = {27'd0, L3};
    localparam logic [35:0] HI = {18'd0, L3, L2}, LO = {18'd0, L1, L0};
    localparam logic [35:0] LW = 36'h9_8765_4321;
    localparam logic [35:0] Z  = 36'd0;
    localparam int NVEC = 6;

    localparam vec_t VECS [NVEC] = '{
        '{narrow:1'b0, size:1'b0, order:1'b0, word:LW,  count:3'd1, exp:{Z, Z, Z, LW}},    // R1
        '{narrow:1'b0, size:1'b1, order:1'b1, word:WIN, count:3'd1, exp:{Z, Z, Z, WIN}},   // R1 size ignored
        '{narrow:1'b1, size:1'b0, order:1'b1, word:WIN, count:3'd2, exp:{Z, Z, LO, HI}},   // R2 R4
        '{narrow:1'b1, size:1'b0, order:1'b0, word:WIN, count:3'd2, exp:{Z, Z, HI, LO}},   // R2 R5
        '{narrow:1'b1, size:1'b1, order:1'b1, word:WIN, count:3'd4, exp:{E0, E1, E2, E3}}, // R3 R4
        '{narrow:1'b1, size:1'b1, order:1'b0, word:WIN, count:3'd4, exp:{E3, E2, E1, E0}}  // R3 R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_en = 1'b0, size_sel = 1'b0, order_pin = 1'b0;
    logic        in_valid = 1'b0, out_ready = 1'b0;
    logic [35:0] in_data = '0;
    logic        in_ready, out_valid;
    logic [35:0] out_data;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_downsizer uut (
        .clk(clk), .rst_n(rst_n), .narrow_en(narrow_en), .size_sel(size_sel),
        .order_pin(order_pin), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset(input logic nar, input logic sz, input logic ord);
        @(negedge clk);
        rst_n = 1'b0; narrow_en = nar; size_sel = sz; order_pin = ord;
        in_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer a word at a negedge while idle; it is captured at the next posedge.
    task automatic push(input logic [35:0] w);
        in_valid = 1'b1; in_data = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req, input vec_t v);
        out_ready = 1'b1;
        for (int j = 0; j < int'(v.count); j++) begin
            check({req, " valid"}, {35'd0, out_valid}, 36'd1);
            check({req, " piece"}, out_data, v.exp[j]);
            @(negedge clk);
        end
        check({req, " no extra piece"}, {35'd0, out_valid}, 36'd0);
        out_ready = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        // R9: reset state
        do_reset(1'b1, 1'b1, 1'b0);
        check("R9 out_valid in reset", {35'd0, out_valid}, 36'd0);
        check("R9 in_ready after reset", {35'd0, in_ready}, 36'd1);

        // Table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            do_reset(VECS[i].narrow, VECS[i].size, VECS[i].order);
            push(VECS[i].word);
            drain($sformatf("vec%0d R1/R2/R3/R4/R5", i), VECS[i]);
        end

        // R6: flip order pin after reset, big order must stay
        do_reset(1'b1, 1'b1, 1'b1);
        @(negedge clk);
        order_pin = 1'b0;
        push(WIN);
        drain("R6 order held", VECS[4]);
        order_pin = 1'b1;

        // R8: stall keeps piece
        do_reset(1'b1, 1'b0, 1'b0);
        push(WIN);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 stalled valid", {35'd0, out_valid}, 36'd1);
            check("R8 stalled data", out_data, LO);
        end
        drain("R8 after stall", VECS[3]);

        // R7: second word offered while pieces pending is not taken
        do_reset(1'b1, 1'b1, 1'b0);
        push(WIN);
        check("R7 in_ready low while busy", {35'd0, in_ready}, 36'd0);
        in_valid = 1'b1; in_data = LW;
        out_ready = 1'b1;
        for (int j = 0; j < 4; j++) begin
            check("R7 piece of first word", out_data, VECS[5].exp[j]);
            @(negedge clk);
        end
        // Now idle with in_valid high: LW captured at this edge
        out_ready = 1'b0;
        check("R7 in_ready after drain", {35'd0, in_ready}, 36'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 second word first lane", out_data, {27'd0, LW[8:0]});

        finish_run();
    end
endmodule